// File: doc/BRIEF.md
# Processor Synchronisation and Console Packet Controller

This block sits between a small load/store processor, its local memory and one local port of a network-on-chip router. It watches every processor access. Accesses to ordinary addresses go straight to the local memory enable. Accesses to three reserved addresses at the top of the address space become network traffic or a stall:

- A store to the top address sends console output to the host.
- A load from the top address asks the host for input and stalls until the answer arrives.
- A store one below the top address blocks the processor until a named peer processor signals it.
- A store two below the top address sends that signal to a named peer.

Every outgoing packet carries four header flits in a fixed order: target router address, payload length, source router address, command code. Data flits follow the header, most significant flit first. The payload length counts the flits that come after it. Incoming flits are parsed with the length field, so every packet is consumed in full. Only a notify packet or a console-input return acts on the processor. A notify that arrives before the matching wait is remembered per source processor. The later wait then completes in the same cycle it is presented.

The processor holds its request and its operands steady while `cpu_wait` is high. An access retires on the first clock edge at which `cpu_wait` is low.

Top module: `sync_noc_ctrl`

## Requirements
- R1: After reset, `cpu_wait`, `tx_valid`, `mem_en` and `cpu_rdata` are all low or zero while no request is presented.
- R2: An access to any address other than the three reserved ones asserts `mem_en` in the same cycle, never raises `cpu_wait`, and sends no packet.
- R3: A store to address FFFFh sends the packet [HOST_ADDR, 4, my_addr, 3, data[15:8], data[7:0]]. `cpu_wait` stays high until the last flit is accepted and is low in the cycle right after that acceptance.
- R4: A load from FFFFh sends [HOST_ADDR, 2, my_addr, 4] and keeps `cpu_wait` high. It waits for an incoming packet with length 4 and command 4 in flit 3, followed by data high then low. In the cycle after the last data flit, `cpu_wait` is low and `cpu_rdata` holds that data.
- R5: A store to FFFDh with value V sends the notify packet [V[7:0], 2, my_addr, 8]. The access is released in the cycle after the last flit is accepted.
- R6: A store to FFFEh with value V stalls the processor. A notify packet whose source flit (flit 2) differs from V does not release it.
- R7: While that wait is stalled, a notify packet (length 2, command 8 in flit 3) whose source flit equals V drops `cpu_wait` in the cycle right after its command flit is accepted.
- R8: A notify that arrives while no wait expects it is recorded for its source. A later wait naming that source completes with `cpu_wait` low from its first cycle. The record is consumed, so a second such wait stalls again.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_flit` stay unchanged.
- R10: Incoming packets with other command codes (for example 9, read return) are skipped using their length field. Payload bytes equal to 8 inside them never count as a notify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr | input | FLIT_W | Router address of this node, sent as the source flit |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | DATA_W | Store data, or processor index for wait/notify |
| cpu_wait | output | 1 | Holds the processor while a reserved access is serviced |
| cpu_rdata | output | DATA_W | Data returned for a console-input load |
| mem_en | output | 1 | Enable for the local memory on ordinary addresses |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts the outgoing flit |
| tx_flit | output | FLIT_W | Outgoing flit |
| rx_valid | input | 1 | Incoming flit valid, always accepted |
| rx_flit | input | FLIT_W | Incoming flit |

## Verification
Every release is tied to a single clock edge. Output accesses are released by the edge that accepts their last transmitted flit. Input loads and waits are released by the edge that accepts the last relevant received flit. In each case `cpu_wait` must read low at the falling edge that follows.

The bench numbers rising edges. It records the edge number of the last flit accepted on each side, and checks that the processor model first sees `cpu_wait` low at exactly that count. A pending-notify wait and an ordinary access must show `cpu_wait` low at the first sample, zero cycles after they are presented. Mismatched notifies and foreign packets are followed by a sample one falling edge later, which must still show the stall.

// File: rtl/sync_noc_pkg.sv
package sync_noc_pkg;

   // Command codes carried in flit 3 of every packet
   localparam int CMD_PRINT  = 3;
   localparam int CMD_SCAN   = 4;
   localparam int CMD_NOTIFY = 8;

   localparam int HDR_FLITS  = 4;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PRINT,
      OP_SCAN,
      OP_WAIT,
      OP_NOTIFY
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_RECV,
      ST_WAITN,
      ST_DONE
   } st_e;

endpackage

// File: rtl/sync_addr_dec.sv
module sync_addr_dec
   import sync_noc_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output op_e               op,
   output logic              mem_en
);

   localparam logic [ADDR_W-1:0] A_IO   = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] A_WAIT = A_IO - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_NTF  = A_IO - ADDR_W'(2);

   always_comb begin
      op = OP_NONE;
      if (req) begin
         if (addr == A_IO)
            op = we ? OP_PRINT : OP_SCAN;
         else if (we && addr == A_WAIT)
            op = OP_WAIT;
         else if (we && addr == A_NTF)
            op = OP_NOTIFY;
      end
   end

   assign mem_en = req && (op == OP_NONE);

endmodule

// File: rtl/sync_tx_gen.sv
module sync_tx_gen
   import sync_noc_pkg::*;
#(
   parameter int FLIT_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FLIT_W-1:0] tgt,
   input  logic [FLIT_W-1:0] src,
   input  logic [FLIT_W-1:0] cmd,
   input  logic              with_data,
   input  logic [DATA_W-1:0] data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [FLIT_W-1:0] tx_flit,
   output logic              done
);

   localparam int NDATA = DATA_W / FLIT_W;
   localparam int TOT   = HDR_FLITS + NDATA;
   localparam int IDX_W = $clog2(TOT);

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [FLIT_W-1:0] tgt_q, src_q, cmd_q;
   logic              wd_q;
   logic [DATA_W-1:0] data_q;
   logic [IDX_W-1:0]  last_idx;
   logic [FLIT_W-1:0] len;
   logic              accept;

   assign last_idx = wd_q ? IDX_W'(TOT - 1) : IDX_W'(HDR_FLITS - 1);
   assign len      = wd_q ? FLIT_W'(2 + NDATA) : FLIT_W'(2);
   assign accept   = busy_q && tx_ready;
   assign done     = accept && (idx_q == last_idx);
   assign tx_valid = busy_q;

   always_comb begin
      if (idx_q == IDX_W'(0))      tx_flit = tgt_q;
      else if (idx_q == IDX_W'(1)) tx_flit = len;
      else if (idx_q == IDX_W'(2)) tx_flit = src_q;
      else if (idx_q == IDX_W'(3)) tx_flit = cmd_q;
      else                         tx_flit = data_q[DATA_W-1 -: FLIT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         tgt_q  <= '0;
         src_q  <= '0;
         cmd_q  <= '0;
         wd_q   <= 1'b0;
         data_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         tgt_q  <= tgt;
         src_q  <= src;
         cmd_q  <= cmd;
         wd_q   <= with_data;
         data_q <= data;
      end else if (accept) begin
         if (done) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
         if (idx_q >= IDX_W'(HDR_FLITS))
            data_q <= data_q << FLIT_W;
      end
   end

endmodule

// File: rtl/sync_rx_parse.sv
module sync_rx_parse
   import sync_noc_pkg::*;
#(
   parameter int FLIT_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [FLIT_W-1:0] rx_flit,
   output logic              ntf_evt,
   output logic [FLIT_W-1:0] ntf_src,
   output logic              ret_evt,
   output logic [DATA_W-1:0] ret_data
);

   localparam int NDATA = DATA_W / FLIT_W;
   localparam int CNT_W = FLIT_W + 2;

   logic [CNT_W-1:0]  idx_q;
   logic [FLIT_W-1:0] len_q, src_q, cmd_q;
   logic [DATA_W-1:0] data_q;
   logic              last_now;

   assign last_now = (idx_q == CNT_W'(1) && rx_flit == '0) ||
                     (idx_q >= CNT_W'(2) && idx_q == CNT_W'(len_q) + CNT_W'(1));

   assign ntf_evt  = rx_valid && idx_q == CNT_W'(3) && len_q == FLIT_W'(2) &&
                     rx_flit == FLIT_W'(CMD_NOTIFY);
   assign ntf_src  = src_q;
   assign ret_evt  = rx_valid && cmd_q == FLIT_W'(CMD_SCAN) &&
                     len_q == FLIT_W'(2 + NDATA) && idx_q == CNT_W'(3 + NDATA);
   assign ret_data = (data_q << FLIT_W) | DATA_W'(rx_flit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         len_q  <= '0;
         src_q  <= '0;
         cmd_q  <= '0;
         data_q <= '0;
      end else if (rx_valid) begin
         if (idx_q == CNT_W'(1))      len_q <= rx_flit;
         else if (idx_q == CNT_W'(2)) src_q <= rx_flit;
         else if (idx_q == CNT_W'(3)) cmd_q <= rx_flit;
         else if (idx_q >= CNT_W'(4)) data_q <= ret_data;
         idx_q <= last_now ? '0 : idx_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/sync_noc_ctrl.sv
module sync_noc_ctrl
   import sync_noc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int FLIT_W    = 8,
   parameter int NPROC     = 4,
   parameter int HOST_ADDR = 0,
   parameter bit PEND_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLIT_W-1:0] my_addr,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_wait,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_en,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [FLIT_W-1:0] tx_flit,
   input  logic              rx_valid,
   input  logic [FLIT_W-1:0] rx_flit
);

   localparam int PID_W = (NPROC > 1) ? $clog2(NPROC) : 1;

   // Elaboration-time parameter checks
   if (DATA_W % FLIT_W != 0) begin : g_bad_dw
      $error("DATA_W must be a whole number of flits");
   end
   if (FLIT_W < 4 || FLIT_W > DATA_W) begin : g_bad_fw
      $error("FLIT_W must hold command codes and not exceed DATA_W");
   end
   if (NPROC < 2 || (NPROC & (NPROC - 1)) != 0) begin : g_bad_np
      $error("NPROC must be a power of two, at least 2");
   end
   if (PID_W > FLIT_W) begin : g_bad_pid
      $error("processor index must fit in one flit");
   end

   op_e               op;
   st_e               state_q;
   logic              recv_after_q;
   logic [FLIT_W-1:0] expect_q;
   logic [DATA_W-1:0] rdata_q;

   logic              tx_start, tx_done, with_data;
   logic [FLIT_W-1:0] tx_tgt, tx_cmd;
   logic              ntf_evt, ret_evt;
   logic [FLIT_W-1:0] ntf_src;
   logic [DATA_W-1:0] ret_data;

   logic [FLIT_W-1:0] v_full;
   logic [PID_W-1:0]  v_id, n_id;
   logic              v_in_range, n_in_range;
   logic              pend_hit, fast_take, early_match, wait_match, ntf_used;

   sync_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .req    (cpu_req),
      .we     (cpu_we),
      .addr   (cpu_addr),
      .op     (op),
      .mem_en (mem_en)
   );

   sync_tx_gen #(.FLIT_W(FLIT_W), .DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tx_start),
      .tgt       (tx_tgt),
      .src       (my_addr),
      .cmd       (tx_cmd),
      .with_data (with_data),
      .data      (cpu_wdata),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_flit   (tx_flit),
      .done      (tx_done)
   );

   sync_rx_parse #(.FLIT_W(FLIT_W), .DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_flit  (rx_flit),
      .ntf_evt  (ntf_evt),
      .ntf_src  (ntf_src),
      .ret_evt  (ret_evt),
      .ret_data (ret_data)
   );

   // Processor index named by the stored value, and by a notify source
   assign v_full     = cpu_wdata[FLIT_W-1:0];
   assign v_id       = v_full[PID_W-1:0];
   assign v_in_range = (v_full >> PID_W) == '0;
   assign n_id       = ntf_src[PID_W-1:0];
   assign n_in_range = (ntf_src >> PID_W) == '0;

   // Pending-notify store: variant chosen by PEND_EN
   if (PEND_EN) begin : g_pend
      logic [NPROC-1:0] pend_q;
      logic [NPROC-1:0] set_vec, clr_vec;

      always_comb begin
         set_vec = '0;
         clr_vec = '0;
         if (ntf_evt && !ntf_used && n_in_range) set_vec[n_id] = 1'b1;
         if (fast_take)                          clr_vec[v_id] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= '0;
         else        pend_q <= (pend_q | set_vec) & ~clr_vec;
      end

      assign pend_hit = v_in_range && pend_q[v_id];
   end else begin : g_nopend
      assign pend_hit = 1'b0;
   end

   assign fast_take   = (state_q == ST_IDLE) && (op == OP_WAIT) && pend_hit;
   assign early_match = (state_q == ST_IDLE) && (op == OP_WAIT) && !fast_take &&
                        ntf_evt && (ntf_src == v_full);
   assign wait_match  = (state_q == ST_WAITN) && ntf_evt && (ntf_src == expect_q);
   assign ntf_used    = early_match || wait_match;

   assign tx_start  = (state_q == ST_IDLE) &&
                      (op == OP_PRINT || op == OP_SCAN || op == OP_NOTIFY);
   assign tx_tgt    = (op == OP_NOTIFY) ? v_full : FLIT_W'(HOST_ADDR);
   assign with_data = (op == OP_PRINT);

   always_comb begin
      case (op)
         OP_PRINT: tx_cmd = FLIT_W'(CMD_PRINT);
         OP_SCAN:  tx_cmd = FLIT_W'(CMD_SCAN);
         default:  tx_cmd = FLIT_W'(CMD_NOTIFY);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         recv_after_q <= 1'b0;
         expect_q     <= '0;
         rdata_q      <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (tx_start) begin
                  state_q      <= ST_SEND;
                  recv_after_q <= (op == OP_SCAN);
               end else if (op == OP_WAIT && !fast_take) begin
                  expect_q <= v_full;
                  state_q  <= early_match ? ST_DONE : ST_WAITN;
               end
            end
            ST_SEND: begin
               if (tx_done) state_q <= recv_after_q ? ST_RECV : ST_DONE;
            end
            ST_RECV: begin
               if (ret_evt) begin
                  rdata_q <= ret_data;
                  state_q <= ST_DONE;
               end
            end
            ST_WAITN: begin
               if (wait_match) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_wait  = (op != OP_NONE) && (state_q != ST_DONE) && !fast_take;
   assign cpu_rdata = rdata_q;

endmodule

// File: rtl/sync_noc_ctrl_chk.sv
module sync_noc_ctrl_chk #(
   parameter int FLIT_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_wait,
   input logic              mem_en,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [FLIT_W-1:0] tx_flit,
   input logic [DATA_W-1:0] cpu_rdata
);

   // R2: with no request the processor is never held
   a_r2_no_req_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> !cpu_wait);

   // R2: ordinary memory accesses are never stalled
   a_r2_mem_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !cpu_wait);

   // R9: a flit refused by the router is held unchanged
   a_r9_flit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit));

   // R3: packets only leave while the requesting access is stalled
   a_r3_send_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> cpu_wait);

   // R4: returned data only changes as the stall is released
   a_r4_rdata_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_rdata) |-> !cpu_wait);

endmodule

bind sync_noc_ctrl sync_noc_ctrl_chk #(.FLIT_W(FLIT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_wait  (cpu_wait),
   .mem_en    (mem_en),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_flit   (tx_flit),
   .cpu_rdata (cpu_rdata)
);

// File: tb/sync_noc_ctrl_bench.sv
module sync_noc_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  my_addr = 8'h01;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_wait;
   logic [15:0] cpu_rdata;
   logic        mem_en;
   logic        tx_valid;
   logic        tx_ready = 1'b1;
   logic [7:0]  tx_flit;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_flit = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int tx_n = 0;
   int tx_last_cyc = 0;
   int rx_last_cyc = 0;
   bit bp = 1'b0;
   logic [7:0] tx_log [64];

   sync_noc_ctrl u_sync_noc_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .my_addr   (my_addr),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_wait  (cpu_wait),
      .cpu_rdata (cpu_rdata),
      .mem_en    (mem_en),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_flit   (tx_flit),
      .rx_valid  (rx_valid),
      .rx_flit   (rx_flit)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         tx_log[tx_n[5:0]] <= tx_flit;
         tx_n        <= tx_n + 1;
         tx_last_cyc <= cyc + 1;
      end
   end

   always @(negedge clk) tx_ready = bp ? ((cyc % 3) != 0) : 1'b1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_access(input logic we, input logic [15:0] addr, input logic [15:0] wd,
                             output int st, output int rel, output logic [15:0] rd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      #1;
      st = 0;
      while (cpu_wait) begin
         @(negedge clk);
         st++;
      end
      rel = cyc;
      rd  = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0;
   endtask

   task automatic rx_pkt(input logic [7:0] src, input logic [7:0] cmd,
                         input int ndata, input logic [15:0] data);
      logic [7:0] f [6];
      f[0] = my_addr; f[1] = 8'(2 + ndata); f[2] = src; f[3] = cmd;
      f[4] = data[15:8]; f[5] = data[7:0];
      for (int i = 0; i < 4 + ndata; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_flit = f[i];
         @(posedge clk);
         #1 rx_last_cyc = cyc;
      end
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R1 cpu_wait", 32'(cpu_wait), 0);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 mem_en", 32'(mem_en), 0);
      chk("R1 cpu_rdata", 32'(cpu_rdata), 0);
   endtask

   task automatic t_plain_access();
      int n0 = tx_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h0040; cpu_wdata = 16'h1234;
      #1;
      chk("R2 mem_en", 32'(mem_en), 1);
      chk("R2 cpu_wait", 32'(cpu_wait), 0);
      @(negedge clk);
      cpu_addr = 16'hFFFC; cpu_we = 1'b0;
      #1;
      chk("R2 near-top load no wait", 32'(cpu_wait), 0);
      @(posedge clk);
      #1 cpu_req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 no packet", 32'(tx_n), 32'(n0));
   endtask

   task automatic t_printf();
      int st, rel, n0;
      logic [15:0] rd;
      n0 = tx_n;
      bp = 1'b1;
      cpu_access(1'b1, 16'hFFFF, 16'hA5C3, st, rel, rd);
      bp = 1'b0;
      chk("R3 flit count", 32'(tx_n - n0), 6);
      chk("R3 flit0 host", 32'(tx_log[n0 % 64]), 32'h00);
      chk("R3 flit1 len", 32'(tx_log[(n0 + 1) % 64]), 32'h04);
      chk("R3 flit2 src", 32'(tx_log[(n0 + 2) % 64]), 32'h01);
      chk("R3 flit3 cmd", 32'(tx_log[(n0 + 3) % 64]), 32'h03);
      chk("R9 flit4 data hi under backpressure", 32'(tx_log[(n0 + 4) % 64]), 32'hA5);
      chk("R9 flit5 data lo under backpressure", 32'(tx_log[(n0 + 5) % 64]), 32'hC3);
      chk("R3 release cycle", 32'(rel), 32'(tx_last_cyc));
   endtask

   task automatic t_scanf();
      int st, rel, n0;
      logic [15:0] rd;
      n0 = tx_n;
      fork
         cpu_access(1'b0, 16'hFFFF, 16'h0000, st, rel, rd);
         begin
            wait (tx_n == n0 + 4);
            repeat (2) @(negedge clk);
            chk("R4 still stalled before return", 32'(cpu_wait), 1);
            rx_pkt(8'h00, 8'h04, 2, 16'h3C96);
         end
      join
      chk("R4 flit0 host", 32'(tx_log[n0 % 64]), 32'h00);
      chk("R4 flit1 len", 32'(tx_log[(n0 + 1) % 64]), 32'h02);
      chk("R4 flit2 src", 32'(tx_log[(n0 + 2) % 64]), 32'h01);
      chk("R4 flit3 cmd", 32'(tx_log[(n0 + 3) % 64]), 32'h04);
      chk("R4 rdata", 32'(rd), 32'h3C96);
      chk("R4 release cycle", 32'(rel), 32'(rx_last_cyc));
   endtask

   task automatic t_notify_send();
      int st, rel, n0;
      logic [15:0] rd;
      n0 = tx_n;
      cpu_access(1'b1, 16'hFFFD, 16'h0002, st, rel, rd);
      chk("R5 flit count", 32'(tx_n - n0), 4);
      chk("R5 flit0 target", 32'(tx_log[n0 % 64]), 32'h02);
      chk("R5 flit1 len", 32'(tx_log[(n0 + 1) % 64]), 32'h02);
      chk("R5 flit2 src", 32'(tx_log[(n0 + 2) % 64]), 32'h01);
      chk("R5 flit3 cmd", 32'(tx_log[(n0 + 3) % 64]), 32'h08);
      chk("R5 release cycle", 32'(rel), 32'(tx_last_cyc));
   endtask

   task automatic t_wait_filter();
      int st, rel;
      logic [15:0] rd;
      fork
         cpu_access(1'b1, 16'hFFFE, 16'h0002, st, rel, rd);
         begin
            repeat (3) @(negedge clk);
            rx_pkt(8'h02, 8'h09, 2, 16'h0808);
            chk("R10 foreign packet keeps stall", 32'(cpu_wait), 1);
            rx_pkt(8'h01, 8'h08, 0, 16'h0000);
            chk("R6 wrong source keeps stall", 32'(cpu_wait), 1);
            repeat (2) @(negedge clk);
            rx_pkt(8'h02, 8'h08, 0, 16'h0000);
         end
      join
      chk("R7 release cycle", 32'(rel), 32'(rx_last_cyc));
   endtask

   task automatic t_pending();
      int st, rel;
      logic [15:0] rd;
      // notify from 1 was recorded during t_wait_filter
      cpu_access(1'b1, 16'hFFFE, 16'h0001, st, rel, rd);
      chk("R8 pending wait no stall", 32'(st), 0);
      fork
         cpu_access(1'b1, 16'hFFFE, 16'h0001, st, rel, rd);
         begin
            repeat (4) @(negedge clk);
            chk("R8 record consumed, stalls again", 32'(cpu_wait), 1);
            rx_pkt(8'h01, 8'h08, 0, 16'h0000);
         end
      join
      chk("R8 second wait release cycle", 32'(rel), 32'(rx_last_cyc));
      // early notify while idle, then wait on it
      rx_pkt(8'h03, 8'h08, 0, 16'h0000);
      cpu_access(1'b1, 16'hFFFE, 16'h0003, st, rel, rd);
      chk("R8 early notify from idle", 32'(st), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_plain_access();
      t_printf();
      t_scanf();
      t_notify_send();
      t_wait_filter();
      t_pending();
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule